// File: doc/BRIEF.md
# MSB-Justified Stereo Audio Serial Transmitter

This block is the master side of a stereo audio serial link. Left and right sample words come in as a pair on a parallel valid/ready interface and are held in a one-entry buffer. The block sends them out on three lines: a bit clock, a word-select line and a serial data line. Each channel slot begins at the word-select transition with the sample MSB, with no extra delay bit, and any bits left in the slot after the sample are zeros.

The bit clock is derived from the system clock. Each half of a bit period lasts `HALF_DIV` system cycles. Software-visible settings arrive as plain input pins:

- sample width (16, 24 or 32 bits),
- slot width (16 or 32 bits),
- idle level of the bit clock.

These pins are captured only while the transmitter is disabled. Raising `enable` always starts a fresh left slot. If no sample pair is waiting when a frame begins, the block sends a silent frame and raises a flag that stays set until the block is disabled.

Top module: `msbj_audio_tx`

## Requirements
- R1: After reset, `s_ready` is 1, and `sck`, `ws`, `sd` and `underrun` are all 0. While disabled, `sck` rests at the level of `cfg_idle_hi` (0 = low, 1 = high).
- R2: `cfg_dlen` selects the sample width: 2'b00 = 16 bits, 2'b01 = 24 bits, 2'b10 = 32 bits, and 2'b11 is treated as 16 bits. The sample is taken from the low-order bits of `s_left`/`s_right`, and the upper bits are ignored.
- R3: `cfg_slot32` selects the slot width (0 = 16 bits, 1 = 32 bits). A 32-bit sample width with `cfg_slot32` = 0 is run with 32-bit slots.
- R4: Each slot carries its sample MSB first, with the MSB in the first bit period after the word-select transition. The bits after the sample's LSB, up to the end of the slot, are 0.
- R5: `ws` is 1 during the left slot and 0 during the right slot. The left slot comes first in each frame, and the first slot after enable is a left slot.
- R6: `sd` and `ws` change only when `sck` moves from its active level to its idle level, or at enable/disable. The active edge (idle level to active level) is where a receiver samples. A bit period is 2*`HALF_DIV` system cycles.
- R7: `s_ready` is 1 exactly when the one-entry pair buffer is empty. A pair is accepted on a clock edge where `s_valid` and `s_ready` are both 1. A buffered pair is consumed at the start of the next frame.
- R8: If the buffer is empty when a frame starts, both slots of that frame are all zeros and `underrun` becomes 1. It stays 1 while enabled and does not rise while pairs keep arriving in time.
- R9: `cfg_dlen`, `cfg_slot32` and `cfg_idle_hi` are captured only while `enable` is 0. Changing them while enabled has no effect on the output stream.
- R10: One cycle after `enable` is sampled low, `ws` and `sd` are 0, `sck` is at its idle level and `underrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Transmitter run control |
| cfg_dlen | input | 2 | Sample width code |
| cfg_slot32 | input | 1 | Slot width select (1 = 32 bits) |
| cfg_idle_hi | input | 1 | Bit clock idle level |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Pair buffer empty |
| s_left | input | 32 | Left sample, right-aligned |
| s_right | input | 32 | Right sample, right-aligned |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select (1 = left) |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The last falling bit-clock edge of a right slot is also a frame start. On that edge the block must launch the next left MSB, switch `ws` high, and decide between popping the buffer and declaring an underrun. To provoke the coincidence, the bench refills the buffer only as `s_ready` returns and then withholds the next pair. The scoreboard must then see the fed frames intact, followed by a frame of zeros with the flag set. Configuration pins toggled mid-stream must also leave the expected words unchanged.

// File: rtl/msbj_pkg.sv
package msbj_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CNT_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    DL_16  = 2'b00,
    DL_24  = 2'b01,
    DL_32  = 2'b10,
    DL_RSV = 2'b11
  } dlen_e;

  typedef struct packed {
    dlen_e dlen;
    logic  slot32;
    logic  idle_hi;
  } cfg_t;

  // number of meaningful sample bits for a width code
  function automatic logic [CNT_W:0] data_bits(dlen_e d);
    case (d)
      DL_24:   return (CNT_W+1)'(24);
      DL_32:   return (CNT_W+1)'(WORD_W);
      default: return (CNT_W+1)'(16);
    endcase
  endfunction
endpackage

// File: rtl/msbj_tick_gen.sv
module msbj_tick_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] cnt;
  logic          high;
  logic          wrap;

  assign wrap   = run && (cnt == LAST);
  assign rise_o = wrap && !high;
  assign fall_o = wrap && high;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      high <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      high <= ~high;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/msbj_pair_buf.sv
module msbj_pair_buf #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_l,
  input  logic [W-1:0] in_r,
  input  logic         pop,
  output logic         full_o,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_r
);
  logic full;
  logic take;

  assign take     = in_valid && !full;
  assign in_ready = !full;
  assign full_o   = full;

  always_ff @(posedge clk) begin
    if (rst)       full <= 1'b0;
    else if (pop)  full <= 1'b0;
    else if (take) full <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_l <= in_l;
      out_r <= in_r;
    end
  end
endmodule

// File: rtl/msbj_align.sv
module msbj_align
  import msbj_pkg::*;
(
  input  logic [WORD_W-1:0] sample_i,
  input  dlen_e             dlen_i,
  output logic [WORD_W-1:0] word_o
);
  logic [CNT_W:0] pad;

  // move the sample MSB to the top bit; vacated low bits become zero
  always_comb begin
    pad    = (CNT_W+1)'(WORD_W) - data_bits(dlen_i);
    word_o = sample_i << pad;
  end
endmodule

// File: rtl/msbj_audio_tx.sv
module msbj_audio_tx
  import msbj_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [1:0]        cfg_dlen,
  input  logic              cfg_slot32,
  input  logic              cfg_idle_hi,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  output logic              sck,
  output logic              ws,
  output logic              sd,
  output logic              underrun
);
  localparam logic [CNT_W-1:0] LAST32 = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST16 = CNT_W'(WORD_W / 2 - 1);

  cfg_t              cfg_q;
  logic              run;
  logic              in_right;
  logic [CNT_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  slot_last;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] right_hold;
  logic              rise, fall;
  logic              buf_full;
  logic [WORD_W-1:0] buf_l, buf_r;
  logic [WORD_W-1:0] al_l, al_r;
  logic              frame_start;

  msbj_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run), .rise_o(rise), .fall_o(fall)
  );

  msbj_pair_buf #(.W(WORD_W)) u_buf (
    .clk(clk), .rst(rst), .in_valid(s_valid), .in_ready(s_ready),
    .in_l(s_left), .in_r(s_right), .pop(frame_start && buf_full),
    .full_o(buf_full), .out_l(buf_l), .out_r(buf_r)
  );

  msbj_align u_al_l (.sample_i(buf_l), .dlen_i(cfg_q.dlen), .word_o(al_l));
  msbj_align u_al_r (.sample_i(buf_r), .dlen_i(cfg_q.dlen), .word_o(al_r));

  assign slot_last   = cfg_q.slot32 ? LAST32 : LAST16;
  assign frame_start = enable &&
                       (!run || (fall && in_right && (bit_idx == slot_last)));

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      cfg_q      <= '{dlen: DL_16, slot32: 1'b0, idle_hi: 1'b0};
      sck        <= 1'b0;
      ws         <= 1'b0;
      sd         <= 1'b0;
      underrun   <= 1'b0;
      in_right   <= 1'b0;
      bit_idx    <= '0;
      shreg      <= '0;
      right_hold <= '0;
    end else if (!enable) begin
      // settings are captured only here
      run           <= 1'b0;
      cfg_q.dlen    <= dlen_e'(cfg_dlen);
      cfg_q.slot32  <= cfg_slot32 | (cfg_dlen == 2'b10);
      cfg_q.idle_hi <= cfg_idle_hi;
      sck           <= cfg_idle_hi;
      ws            <= 1'b0;
      sd            <= 1'b0;
      underrun      <= 1'b0;
      in_right      <= 1'b0;
      bit_idx       <= '0;
    end else begin
      run <= 1'b1;
      if (rise) sck <= ~cfg_q.idle_hi;
      if (fall) sck <= cfg_q.idle_hi;
      if (frame_start) begin
        bit_idx    <= '0;
        in_right   <= 1'b0;
        ws         <= 1'b1;
        sd         <= buf_full ? al_l[WORD_W-1] : 1'b0;
        shreg      <= buf_full ? (al_l << 1) : '0;
        right_hold <= buf_full ? al_r : '0;
        if (!buf_full) underrun <= 1'b1;
      end else if (fall) begin
        if (bit_idx == slot_last) begin
          bit_idx  <= '0;
          in_right <= 1'b1;
          ws       <= 1'b0;
          sd       <= right_hold[WORD_W-1];
          shreg    <= right_hold << 1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          sd      <= shreg[WORD_W-1];
          shreg   <= shreg << 1;
        end
      end
    end
  end
endmodule

// File: rtl/msbj_audio_tx_chk.sv
module msbj_audio_tx_chk
  import msbj_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             cfg_idle_hi,
  input logic             s_valid,
  input logic             s_ready,
  input logic             sck,
  input logic             ws,
  input logic             sd,
  input logic             underrun,
  input logic             run,
  input logic             idle_hi_q,
  input logic             slot32_q,
  input logic [CNT_W-1:0] bit_idx
);
  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(enable) && !$past(rst)) |->
      (!ws && !sd && !underrun && (sck == $past(cfg_idle_hi))));

  // R6
  ws_launch_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && $past(enable) && !$stable(ws)) |->
      ((sck == idle_hi_q) && ($past(sck) != idle_hi_q)));

  // R6
  sd_launch_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && $past(enable) && !$stable(sd)) |->
      ((sck == idle_hi_q) && ($past(sck) != idle_hi_q)));

  // R7
  one_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && $past(underrun)) |-> underrun);

  // R3
  slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !slot32_q) |-> (bit_idx < CNT_W'(WORD_W / 2)));
endmodule

bind msbj_audio_tx msbj_audio_tx_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .cfg_idle_hi(cfg_idle_hi),
  .s_valid(s_valid), .s_ready(s_ready), .sck(sck), .ws(ws), .sd(sd),
  .underrun(underrun), .run(run), .idle_hi_q(cfg_q.idle_hi),
  .slot32_q(cfg_q.slot32), .bit_idx(bit_idx)
);

// File: tb/msbj_audio_tx_test.sv
`timescale 1ns/1ps
module msbj_audio_tx_test;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [1:0]  cfg_dlen = 2'b00;
  logic        cfg_slot32 = 1'b0;
  logic        cfg_idle_hi = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_left = '0;
  logic [31:0] s_right = '0;
  logic        s_ready, sck, ws, sd, underrun;

  always #4 clk = ~clk;

  msbj_audio_tx #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_dlen(cfg_dlen),
    .cfg_slot32(cfg_slot32), .cfg_idle_hi(cfg_idle_hi), .s_valid(s_valid),
    .s_ready(s_ready), .s_left(s_left), .s_right(s_right), .sck(sck),
    .ws(ws), .sd(sd), .underrun(underrun)
  );

  int          n_checks = 0;
  int          n_fail = 0;
  logic [31:0] exp_w[$];
  logic        exp_ws[$];
  int          mon_done = 0;
  int          slot_len = 16;
  logic        mon_idle = 1'b0;
  string       data_tag = "R4";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_slot(logic [31:0] s, logic [1:0] dl, logic ch);
    int dw, sw;
    logic [31:0] m;
    dw = (dl == 2'b01) ? 24 : (dl == 2'b10) ? 32 : 16;
    sw = (ch || dl == 2'b10) ? 32 : 16;
    m  = (dw == 32) ? s : (s & ((32'h1 << dw) - 1));
    return m << (sw - dw);
  endfunction

  // monitor: collects bits at the receiver's sampling edge
  logic        prev_sck = 1'b0;
  int          bits = 0;
  int          per = 0;
  logic [31:0] acc = '0;
  logic        first_ws = 1'b0;
  bit          ws_bad = 0, per_bad = 0, seen_edge = 0;
  logic [31:0] ew;
  logic        ews;

  always @(negedge clk) begin
    if (rst || !enable) begin
      bits = 0; acc = '0; ws_bad = 0; per_bad = 0; seen_edge = 0; per = 0;
      prev_sck = sck;
    end else begin
      per++;
      if (prev_sck == mon_idle && sck != mon_idle) begin
        if (seen_edge && per != 2 * HALF) per_bad = 1;
        seen_edge = 1;
        per = 0;
        if (bits == 0) first_ws = ws;
        else if (ws != first_ws) ws_bad = 1;
        acc = {acc[30:0], sd};
        bits++;
        if (bits == slot_len) begin
          if (exp_w.size() > 0) begin
            ew  = exp_w.pop_front();
            ews = exp_ws.pop_front();
            check(acc == ew, data_tag, "slot word", acc, ew);
            // R5
            check(first_ws == ews && !ws_bad, "R5", "ws level in slot", {31'b0, first_ws}, {31'b0, ews});
            // R6
            check(!per_bad, "R6", "bit period", {31'b0, per_bad}, 32'd0);
            mon_done++;
          end
          bits = 0; acc = '0; ws_bad = 0; per_bad = 0;
        end
      end
      prev_sck = sck;
    end
  end

  task automatic push(input logic [31:0] l, input logic [31:0] r,
                      input logic [1:0] dl, input logic ch);
    do @(negedge clk); while (!s_ready);
    s_valid = 1'b1; s_left = l; s_right = r;
    @(negedge clk);
    s_valid = 1'b0;
    // R7
    check(!s_ready, "R7", "ready after accept", {31'b0, s_ready}, 32'd0);
    exp_w.push_back(exp_slot(l, dl, ch)); exp_ws.push_back(1'b1);
    exp_w.push_back(exp_slot(r, dl, ch)); exp_ws.push_back(1'b0);
  endtask

  task automatic run_cfg(input logic [1:0] dl, input logic ch, input logic ih,
                         input int n, input bit scramble, input string tag);
    int target;
    enable = 1'b0; cfg_dlen = dl; cfg_slot32 = ch; cfg_idle_hi = ih;
    mon_idle = ih; data_tag = tag;
    slot_len = (ch || dl == 2'b10) ? 32 : 16;
    repeat (3) @(negedge clk);
    // R1
    check(sck == ih, "R1", "idle clock level", {31'b0, sck}, {31'b0, ih});
    check(!ws && !sd, "R1", "idle ws/sd", {30'b0, ws, sd}, 32'd0);
    target = mon_done + 2 * (n + 1);
    push($urandom, $urandom, dl, ch);
    enable = 1'b1;
    if (scramble) begin
      // R9: pins move while running
      repeat (6) @(negedge clk);
      cfg_dlen = ~dl; cfg_slot32 = ~ch; cfg_idle_hi = ~ih;
    end
    for (int i = 1; i < n; i++) push($urandom, $urandom, dl, ch);
    // R8
    check(!underrun, "R8", "no underrun while fed", {31'b0, underrun}, 32'd0);
    exp_w.push_back('0); exp_ws.push_back(1'b1);
    exp_w.push_back('0); exp_ws.push_back(1'b0);
    while (mon_done < target) @(negedge clk);
    // R8
    check(underrun, "R8", "underrun after starvation", {31'b0, underrun}, 32'd1);
    cfg_dlen = dl; cfg_slot32 = ch; cfg_idle_hi = ih;
    enable = 1'b0;
    @(negedge clk);
    // R10
    check(!ws && !sd, "R10", "outputs idle after disable", {30'b0, ws, sd}, 32'd0);
    check(sck == ih, "R10", "clock idle after disable", {31'b0, sck}, {31'b0, ih});
    check(!underrun, "R10", "flag cleared on disable", {31'b0, underrun}, 32'd0);
    exp_w.delete(); exp_ws.delete();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(s_ready, "R1", "reset ready", {31'b0, s_ready}, 32'd1);
    check(!sck && !ws && !sd && !underrun, "R1", "reset outputs",
          {28'b0, sck, ws, sd, underrun}, 32'd0);
    run_cfg(2'b00, 1'b0, 1'b0, 3, 1'b0, "R4");   // 16 in 16
    run_cfg(2'b01, 1'b1, 1'b1, 3, 1'b1, "R9");   // 24 in 32, pins scrambled
    run_cfg(2'b10, 1'b0, 1'b0, 2, 1'b0, "R3");   // 32-bit forces 32 slot
    run_cfg(2'b00, 1'b1, 1'b1, 2, 1'b0, "R4");   // 16 in 32, zero pad
    run_cfg(2'b11, 1'b0, 1'b0, 2, 1'b0, "R2");   // reserved code as 16
    report();
    $finish;
  end
endmodule